// File: doc/BRIEF.md
# Sector Erase Accumulation Window Timer

This block governs the short acceptance window that comes before a multi-sector erase. The first sector erase command opens a timeout window and marks its sector in an erase-select bitmap. Any further sector erase command that arrives before the timeout ends adds its sector to the bitmap and starts the full timeout again. When the timeout runs out, the window status bit goes high and a fixed-length erase busy period begins. A chip erase command selects every sector and starts the busy period at once, with no window.

After the window has closed, only suspend and resume commands have an effect. Suspend pauses the busy countdown and resume continues it. When the countdown finishes, the bitmap clears and the block goes back to idle. Any command that is not a sector erase or a suspend, if it arrives while the window is still open, cancels the accumulation without erasing.

Command kinds are presented one per cycle on `cmd_kind_i`, qualified by `cmd_valid_i`. The encodings are: 1 = sector erase, 2 = chip erase, 3 = suspend, 4 = resume. Any other value (0, 5, 6, 7) is an unrelated command.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `sel_map_o` is all zero, and `window_closed_o` and `erase_active_o` are 0.
- R2: In idle, a sector erase command (kind 1) with index i sets bit i of `sel_map_o` on the capture edge, and `window_closed_o` stays 0.
- R3: `window_closed_o` and `erase_active_o` both rise exactly WINDOW_CYCLES cycles after the capture edge of the last accepted sector erase command.
- R4: A sector erase command inside the open window adds its bit to the existing bitmap, never removes a bit, and restarts the full WINDOW_CYCLES timeout.
- R5: In idle, a chip erase command (kind 2) sets every bitmap bit and raises `window_closed_o` and `erase_active_o` on the capture edge, with no window.
- R6: While `window_closed_o` is 1, sector erase, chip erase and unrelated commands change neither the bitmap nor the erase progress.
- R7: In the open window, a chip erase, resume or unrelated command clears the bitmap and returns to idle, and no erase follows.
- R8: A suspend (kind 3) during an erase drops `erase_active_o` while `window_closed_o` and the bitmap hold. A resume (kind 4) raises `erase_active_o` again, and the total number of active cycles is still ERASE_CYCLES.
- R9: After ERASE_CYCLES active cycles, the bitmap clears and `window_closed_o` and `erase_active_o` fall on the same edge.
- R10: A suspend inside the open window has no effect. In idle, suspend, resume and unrelated commands have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_kind_i | input | 3 | Command kind encoding |
| sector_idx_i | input | $clog2(NUM_SECTORS) | Sector index for a sector erase |
| sel_map_o | output | NUM_SECTORS | Selected-sector bitmap |
| window_closed_o | output | 1 | 0 while the window accepts sectors; 1 once erase has started |
| erase_active_o | output | 1 | Erase busy countdown is running (not suspended) |

## Verification
Every result is registered, so the bitmap and status outputs reflect a command in the cycle that follows its capture edge. Window closure is due exactly WINDOW_CYCLES cycles after the last accepted sector command, and it is also checked one cycle earlier to catch off-by-one errors. Erase completion is due ERASE_CYCLES active cycles after closure, moved later by the length of any suspension. The bench records the capture cycle of each command and files expected outputs against absolute cycle numbers. A monitor samples at the falling edge and compares only the entries that fall due in that cycle.

// File: rtl/sew_pkg.sv
package sew_pkg;
  localparam logic [2:0] CMD_SECTOR  = 3'd1;
  localparam logic [2:0] CMD_CHIP    = 3'd2;
  localparam logic [2:0] CMD_SUSPEND = 3'd3;
  localparam logic [2:0] CMD_RESUME  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WINDOW,
    ST_ERASE,
    ST_SUSP
  } sew_state_e;

  typedef struct packed {
    logic sector;
    logic chip;
    logic suspend;
    logic resume;
    logic other;
  } sew_cmd_t;
endpackage

// File: rtl/sew_cmd_decode.sv
module sew_cmd_decode
  import sew_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SECW        = 3
) (
  input  logic                   valid_i,
  input  logic [2:0]             kind_i,
  input  logic [SECW-1:0]        idx_i,
  output sew_cmd_t               cmd_o,
  output logic [NUM_SECTORS-1:0] sector_oh_o
);
  always_comb begin
    cmd_o         = '0;
    cmd_o.sector  = valid_i && (kind_i == CMD_SECTOR);
    cmd_o.chip    = valid_i && (kind_i == CMD_CHIP);
    cmd_o.suspend = valid_i && (kind_i == CMD_SUSPEND);
    cmd_o.resume  = valid_i && (kind_i == CMD_RESUME);
    cmd_o.other   = valid_i && !(cmd_o.sector || cmd_o.chip || cmd_o.suspend || cmd_o.resume);
  end

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_oh
    assign sector_oh_o[g] = (idx_i == SECW'(g));
  end
endmodule

// File: rtl/sew_down_counter.sv
module sew_down_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             en_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sew_sector_map.sv
module sew_sector_map #(
  parameter int NUM_SECTORS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   set_i,
  input  logic [NUM_SECTORS-1:0] set_mask_i,
  output logic [NUM_SECTORS-1:0] map_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      map_o <= '0;
    else if (clear_i) map_o <= '0;
    else if (set_i)   map_o <= map_o | set_mask_i;
  end
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
  import sew_pkg::*;
#(
  parameter int NUM_SECTORS   = 8,
  parameter int WINDOW_CYCLES = 16,
  parameter int ERASE_CYCLES  = 32,
  localparam int SECW  = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  input  logic [2:0]             cmd_kind_i,
  input  logic [SECW-1:0]        sector_idx_i,
  output logic [NUM_SECTORS-1:0] sel_map_o,
  output logic                   window_closed_o,
  output logic                   erase_active_o
);
  localparam int WIN_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam int ERS_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_RELOAD = WIN_W'(WINDOW_CYCLES - 1);
  localparam logic [ERS_W-1:0] ERS_RELOAD = ERS_W'(ERASE_CYCLES - 1);

  sew_state_e state_q, state_d;
  sew_cmd_t   cmd;
  logic [NUM_SECTORS-1:0] sector_oh, map_mask;
  logic win_load, win_en, win_zero;
  logic ers_load, ers_en, ers_zero;
  logic map_clear, map_set;

  sew_cmd_decode #(.NUM_SECTORS(NUM_SECTORS), .SECW(SECW)) u_dec (
    .valid_i     (cmd_valid_i),
    .kind_i      (cmd_kind_i),
    .idx_i       (sector_idx_i),
    .cmd_o       (cmd),
    .sector_oh_o (sector_oh)
  );

  sew_down_counter #(.WIDTH(WIN_W)) u_win_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (win_load),
    .load_val_i (WIN_RELOAD),
    .en_i       (win_en),
    .zero_o     (win_zero)
  );

  sew_down_counter #(.WIDTH(ERS_W)) u_ers_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ers_load),
    .load_val_i (ERS_RELOAD),
    .en_i       (ers_en),
    .zero_o     (ers_zero)
  );

  sew_sector_map #(.NUM_SECTORS(NUM_SECTORS)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (map_clear),
    .set_i      (map_set),
    .set_mask_i (map_mask),
    .map_o      (sel_map_o)
  );

  always_comb begin
    state_d   = state_q;
    win_load  = 1'b0;
    win_en    = 1'b0;
    ers_load  = 1'b0;
    ers_en    = 1'b0;
    map_clear = 1'b0;
    map_set   = 1'b0;
    map_mask  = sector_oh;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd.sector) begin
          state_d  = ST_WINDOW;
          win_load = 1'b1;
          map_set  = 1'b1;
        end else if (cmd.chip) begin
          state_d  = ST_ERASE;
          ers_load = 1'b1;
          map_set  = 1'b1;
          map_mask = '1;
        end
      end
      ST_WINDOW: begin
        if (cmd.sector) begin
          win_load = 1'b1;
          map_set  = 1'b1;
        end else if (cmd.chip || cmd.resume || cmd.other) begin
          state_d   = ST_IDLE;
          map_clear = 1'b1;
        end else if (win_zero) begin
          state_d  = ST_ERASE;
          ers_load = 1'b1;
        end else begin
          win_en = 1'b1;
        end
      end
      ST_ERASE: begin
        // completion wins over a same-cycle suspend; the cycle that carries
        // the suspend is still an active cycle and counts down
        if (ers_zero) begin
          state_d   = ST_IDLE;
          map_clear = 1'b1;
        end else begin
          ers_en = 1'b1;
          if (cmd.suspend) state_d = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (cmd.resume) state_d = ST_ERASE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign window_closed_o = (state_q == ST_ERASE) || (state_q == ST_SUSP);
  assign erase_active_o  = (state_q == ST_ERASE);
endmodule

// File: rtl/sew_checker.sv
module sew_checker #(
  parameter int NUM_SECTORS = 8,
  localparam int SECW = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cmd_valid_i,
  input logic [2:0]             cmd_kind_i,
  input logic [SECW-1:0]        sector_idx_i,
  input logic [NUM_SECTORS-1:0] sel_map_o,
  input logic                   window_closed_o,
  input logic                   erase_active_o
);
  logic is_sector, is_chip;
  assign is_sector = cmd_valid_i && (cmd_kind_i == 3'd1);
  assign is_chip   = cmd_valid_i && (cmd_kind_i == 3'd2);

  AST_SECTOR_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sector && !window_closed_o) |=> (sel_map_o[$past(sector_idx_i)] && !window_closed_o)); // R2

  AST_WINDOW_MAP_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!window_closed_o && !$past(window_closed_o) && (|sel_map_o))
      |-> (($past(sel_map_o) & ~sel_map_o) == '0)); // R4

  AST_CLOSE_STARTS_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(window_closed_o) |-> (erase_active_o && (|sel_map_o))); // R3

  AST_CHIP_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_chip && !window_closed_o && sel_map_o == '0) |=> (window_closed_o && (&sel_map_o))); // R5

  AST_CLOSED_NO_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_closed_o && $past(window_closed_o)) |-> ((sel_map_o & ~$past(sel_map_o)) == '0)); // R6

  AST_EXIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(window_closed_o) |-> (sel_map_o == '0 && !erase_active_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!window_closed_o && sel_map_o == '0 && cmd_valid_i && !is_sector && !is_chip)
      |=> (sel_map_o == '0 && !window_closed_o)); // R10
endmodule

bind sector_erase_window sew_checker #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_valid_i     (cmd_valid_i),
  .cmd_kind_i      (cmd_kind_i),
  .sector_idx_i    (sector_idx_i),
  .sel_map_o       (sel_map_o),
  .window_closed_o (window_closed_o),
  .erase_active_o  (erase_active_o)
);

// File: tb/sim_sector_erase_window.sv
module sim_sector_erase_window;
  localparam int N = 8;
  localparam int W = 16;
  localparam int E = 32;

  localparam logic [2:0] K_SEC = 3'd1, K_CHIP = 3'd2, K_SUSP = 3'd3, K_RES = 3'd4, K_OTH = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_kind = '0;
  logic [2:0] sector_idx = '0;
  logic [N-1:0] sel_map;
  logic closed, active;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  sector_erase_window #(.NUM_SECTORS(N), .WINDOW_CYCLES(W), .ERASE_CYCLES(E)) u0 (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .cmd_valid_i     (cmd_valid),
    .cmd_kind_i      (cmd_kind),
    .sector_idx_i    (sector_idx),
    .sel_map_o       (sel_map),
    .window_closed_o (closed),
    .erase_active_o  (active)
  );

  typedef struct {
    int          due;
    logic [N-1:0] map;
    logic        closed;
    logic        active;
    string       req;
  } exp_t;

  exp_t sb[$];

  // driver side: file an expectation for absolute cycle `due`, kept sorted
  task automatic expect_at(input int due, input logic [N-1:0] m, input logic c,
                           input logic a, input string req);
    exp_t it;
    int pos;
    it.due = due; it.map = m; it.closed = c; it.active = a; it.req = req;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].due > due) begin pos = i; break; end
    end
    sb.insert(pos, it);
  endtask

  task automatic send(input logic [2:0] k, input int idx, output int cap);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_kind = k; sector_idx = 3'(idx);
    @(posedge clk); #1;
    cap = cyc;
    cmd_valid = 1'b0; cmd_kind = '0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) begin @(posedge clk); #1; end
  endtask

  // monitor: compare every entry due in the current cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (it.due < cyc || sel_map !== it.map || closed !== it.closed || active !== it.active) begin
        errors++;
        $display("FAIL %s cycle %0d: map=%h closed=%b active=%b expected map=%h closed=%b active=%b",
                 it.req, it.due, sel_map, closed, active, it.map, it.closed, it.active);
      end
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0, c1, c2, s, r, t;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_at(cyc + 1, '0, 0, 0, "R1");
    wait_until(cyc + 3);

    // accumulation with restart, then commands ignored during erase
    send(K_SEC, 2, c0);
    expect_at(c0, 8'h04, 0, 0, "R2");
    wait_until(c0 + 5);
    send(K_SEC, 6, c1);
    expect_at(c1, 8'h44, 0, 0, "R4");
    expect_at(c0 + W, 8'h44, 0, 0, "R4");
    expect_at(c1 + W - 1, 8'h44, 0, 0, "R3");
    expect_at(c1 + W, 8'h44, 1, 1, "R3");
    wait_until(c1 + W + 2);
    send(K_SEC, 0, t);  expect_at(t, 8'h44, 1, 1, "R6");
    send(K_OTH, 0, t);  expect_at(t, 8'h44, 1, 1, "R6");
    send(K_CHIP, 0, t); expect_at(t, 8'h44, 1, 1, "R6");
    expect_at(c1 + W + E - 1, 8'h44, 1, 1, "R9");
    expect_at(c1 + W + E, '0, 0, 0, "R9");
    wait_until(c1 + W + E + 2);

    // chip erase bypasses window
    send(K_CHIP, 0, c0);
    expect_at(c0, 8'hFF, 1, 1, "R5");
    expect_at(c0 + E - 1, 8'hFF, 1, 1, "R9");
    expect_at(c0 + E, '0, 0, 0, "R9");
    wait_until(c0 + E + 2);

    // cancellation and ignored commands
    send(K_SEC, 3, c0);  expect_at(c0, 8'h08, 0, 0, "R2");
    send(K_SUSP, 0, t);  expect_at(t, 8'h08, 0, 0, "R10");
    send(K_OTH, 0, c2);  expect_at(c2, '0, 0, 0, "R7");
    expect_at(c2 + W + 2, '0, 0, 0, "R7");
    wait_until(c2 + W + 3);
    send(K_SEC, 1, t);   expect_at(t, 8'h02, 0, 0, "R2");
    send(K_CHIP, 0, t);  expect_at(t, '0, 0, 0, "R7");
    send(K_SEC, 4, t);   expect_at(t, 8'h10, 0, 0, "R2");
    send(K_RES, 0, t);   expect_at(t, '0, 0, 0, "R7");
    send(K_RES, 0, t);   expect_at(t, '0, 0, 0, "R10");
    send(K_SUSP, 0, t);  expect_at(t, '0, 0, 0, "R10");
    send(K_OTH, 0, t);   expect_at(t, '0, 0, 0, "R10");
    wait_until(t + W + 2);
    expect_at(cyc, '0, 0, 0, "R10");
    wait_until(cyc + 2);

    // suspend and resume during erase
    send(K_SEC, 7, c0);
    expect_at(c0 + W, 8'h80, 1, 1, "R3");
    wait_until(c0 + W + 4);
    send(K_SUSP, 0, s);
    expect_at(s, 8'h80, 1, 0, "R8");
    send(K_SEC, 0, t);   expect_at(t, 8'h80, 1, 0, "R6");
    wait_until(s + 10);
    expect_at(cyc, 8'h80, 1, 0, "R8");
    send(K_RES, 0, r);
    expect_at(r, 8'h80, 1, 1, "R8");
    expect_at(r + E - (s - c0 - W) - 1, 8'h80, 1, 1, "R8");
    expect_at(r + E - (s - c0 - W), '0, 0, 0, "R9");
    wait_until(r + E + 4);

    if (sb.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: %0d entries left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule